// File: doc/BRIEF.md
# Fractional Bit-Rate Clock Enable Generator

This block turns a fast interface clock into a stream of single-cycle enable pulses that pace a serial bit clock. The rate is not set by an integer divisor. An 8-bit rate code acts as a multiplier over 512, so the average pulse rate is the input clock frequency times code/512. The all-ones code is read as 256, which gives exactly half the input clock. Code 1 gives the slowest rate, the input clock divided by 512. Power-of-two codes give evenly spaced pulses. Other codes give the correct average rate with some jitter of one cycle.

Internally a 9-bit phase accumulator adds the effective code on every cycle while the run input is high. The carry out of each addition becomes the registered enable. When run is low the accumulator is held at zero. Each rise of run therefore starts from a known phase, and the first pulse arrives a fixed number of cycles later. A serial engine downstream qualifies its shift and sample logic with the enable instead of using a derived clock.

Top module: `bitrate_en_gen`

## Requirements
- R1: While rst_n is low, and on the first cycle after it is released, bit_en is 0.
- R2: A clock edge that samples run low leaves bit_en low after that edge and returns the phase to zero, whatever the rate code is.
- R3: Rate code 0 produces no enable pulses, however long run stays high.
- R4: Rate code 8'hFF counts as 256. After run rises, bit_en is 1 after the 2nd, 4th, 6th, ... edges that sample run high, and 0 after the others.
- R5: For a power-of-two code c (1 to 128), bit_en is 1 after exactly the edges whose count since run rose is a multiple of 512/c.
- R6: For any code c from 1 to 254, bit_en after the n-th edge with run high is 1 exactly when floor(n*c/512) > floor((n-1)*c/512).
- R7: bit_en is never high on two consecutive cycles.
- R8: Dropping run for a single edge in the middle of a phase restarts the pulse pattern from its beginning.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast interface clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rate_code | input | 8 | Rate multiplier over 512; 8'hFF means 256 |
| run | input | 1 | High to advance the phase; low holds it at zero |
| bit_en | output | 1 | Single-cycle bit-clock enable pulse |

## Verification
The assertions assume that rate_code and run are synchronous to clk and settle before each rising edge. They also assume that the phase starts from zero after reset, which the clear on a low run guarantees. The bench changes both inputs only at falling edges. Every measured run is preceded by at least one edge with run low, so the expected pulse pattern can always be counted from a known zero phase. The rate code is held constant within each measured run, so the closed-form pulse count applies unchanged from the first edge to the last.

// File: rtl/brg_pkg.sv
package brg_pkg;

  // Default width of the rate code; the phase is one bit wider.
  localparam int unsigned DEF_CODE_W = 8;

endpackage

// File: rtl/rate_code_expand.sv
module rate_code_expand #(
  parameter int unsigned CODE_W = brg_pkg::DEF_CODE_W,
  localparam int unsigned STEP_W = CODE_W + 1
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [STEP_W-1:0] step_o
);

  // The all-ones code stands for a full 2^CODE_W step (half rate).
  function automatic logic [STEP_W-1:0] expand(input logic [CODE_W-1:0] c);
    if (&c) expand = STEP_W'(1) << CODE_W;
    else    expand = {1'b0, c};
  endfunction

  assign step_o = expand(code_i);

endmodule

// File: rtl/phase_accum.sv
module phase_accum #(
  parameter int unsigned ACC_W = brg_pkg::DEF_CODE_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [ACC_W-1:0] step_i,
  output logic [ACC_W-1:0] phase_o,
  output logic             carry_o,
  output logic             tick_o
);

  // Add modulo 2^ACC_W; the extra top bit is the wrap indication.
  function automatic logic [ACC_W:0] add_wrap(input logic [ACC_W-1:0] a,
                                              input logic [ACC_W-1:0] b);
    add_wrap = {1'b0, a} + {1'b0, b};
  endfunction

  logic [ACC_W:0]   sum_w;
  logic [ACC_W-1:0] phase_q;
  logic             tick_q;

  assign sum_w   = add_wrap(phase_q, step_i);
  assign carry_o = sum_w[ACC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      tick_q  <= 1'b0;
    end else if (!run_i) begin
      phase_q <= '0;
      tick_q  <= 1'b0;
    end else begin
      phase_q <= sum_w[ACC_W-1:0];
      tick_q  <= carry_o;
    end
  end

  assign phase_o = phase_q;
  assign tick_o  = tick_q;

endmodule

// File: rtl/bitrate_en_gen.sv
module bitrate_en_gen #(
  parameter int unsigned CODE_W = brg_pkg::DEF_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] rate_code,
  input  logic              run,
  output logic              bit_en
);

  localparam int unsigned ACC_W = CODE_W + 1;

  // Named internal events, visible to the bound checker.
  logic [ACC_W-1:0] eff_step_w;
  logic [ACC_W-1:0] phase_w;
  logic             carry_w;
  logic             tick_w;

  rate_code_expand #(.CODE_W(CODE_W)) u_expand (
    .code_i (rate_code),
    .step_o (eff_step_w)
  );

  phase_accum #(.ACC_W(ACC_W)) u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (run),
    .step_i  (eff_step_w),
    .phase_o (phase_w),
    .carry_o (carry_w),
    .tick_o  (tick_w)
  );

  assign bit_en = tick_w;

endmodule

// File: rtl/bitrate_en_gen_chk.sv
module bitrate_en_gen_chk #(
  parameter int unsigned CODE_W = brg_pkg::DEF_CODE_W,
  localparam int unsigned ACC_W = CODE_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] rate_code,
  input logic              run,
  input logic              bit_en,
  input logic [ACC_W-1:0]  phase_w
);

  localparam logic [ACC_W-1:0] HALF_PHASE = ACC_W'(1) << CODE_W;

  // R1
  always_comb begin
    if (!rst_n) reset_quiet_chk: assert (bit_en == 1'b0);
  end

  // R2
  run_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !bit_en);

  // R2
  run_low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> phase_w == '0);

  // R3
  zero_code_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && rate_code == '0) |=> !bit_en);

  // R4
  full_rate_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (&rate_code) && phase_w == HALF_PHASE) |=> bit_en);

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |=> !bit_en);

endmodule

bind bitrate_en_gen bitrate_en_gen_chk #(.CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rate_code (rate_code),
  .run       (run),
  .bit_en    (bit_en),
  .phase_w   (phase_w)
);

// File: tb/test_bitrate_en_gen.sv
module test_bitrate_en_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rate_code = 8'h00;
  logic       run = 1'b0;
  logic       bit_en;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct {
    logic  exp;
    string req;
    int    idx;
  } item_t;

  item_t sb_q[$];

  always #4 clk = ~clk;

  bitrate_en_gen i_bitrate_en_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .rate_code (rate_code),
    .run       (run),
    .bit_en    (bit_en)
  );

  // Expected pulse after the n-th active edge: integer part of n*e/512 steps up.
  function automatic logic expect_pulse(input logic [7:0] c, input int n);
    int e;
    e = (c == 8'hFF) ? 256 : int'(c);
    return ((n * e) / 512) != (((n - 1) * e) / 512);
  endfunction

  task automatic idle(input int cyc, input logic [7:0] c);
    @(negedge clk);
    run = 1'b0;
    rate_code = c;
    for (int k = 1; k <= cyc; k++) begin
      @(posedge clk);
      #1;
      sb_q.push_back('{1'b0, "R2", k});
    end
  endtask

  task automatic run_case(input logic [7:0] c, input int cyc, input string req);
    idle(1, c);
    @(negedge clk);
    run = 1'b1;
    rate_code = c;
    for (int n = 1; n <= cyc; n++) begin
      @(posedge clk);
      #1;
      sb_q.push_back('{expect_pulse(c, n), req, n});
    end
  endtask

  // Monitor: compares away from the active edge.
  always @(negedge clk) begin
    if (sb_q.size() != 0) begin
      item_t it;
      it = sb_q.pop_front();
      total++;
      if (bit_en !== it.exp) begin
        bad++;
        $display("FAIL %s edge %0d: bit_en=%b expected=%b", it.req, it.idx, bit_en, it.exp);
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: quiet during reset even with run and full code applied
    run = 1'b1;
    rate_code = 8'hFF;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      total++;
      if (bit_en !== 1'b0) begin
        bad++;
        $display("FAIL R1 reset: bit_en=%b expected=0", bit_en);
      end
    end
    run = 1'b0;
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    sb_q.push_back('{1'b0, "R1", 0});

    // R2: run low with a nonzero code stays quiet
    idle(20, 8'hFF);
    // R3: zero code never pulses
    run_case(8'h00, 300, "R3");
    // R4: all-ones code is half rate
    run_case(8'hFF, 40, "R4");
    // R5: power-of-two spacing
    run_case(8'h01, 1100, "R5");
    run_case(8'h02, 600, "R5");
    run_case(8'h40, 50, "R5");
    run_case(8'h80, 50, "R5");
    // R6: non-power codes
    run_case(8'h03, 400, "R6");
    run_case(8'd100, 200, "R6");
    run_case(8'd200, 100, "R6");
    // R7: densest non-full code, pulses stay isolated
    run_case(8'd254, 60, "R7");
    // R8: interrupt mid-phase then restart from the beginning
    run_case(8'h03, 100, "R8");
    run_case(8'h03, 200, "R8");

    wait (sb_q.size() == 0);
    @(negedge clk);
    #1;
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule